// File: doc/BRIEF.md
# Time-Slotted ADC Input Sequencer

This block steps an analog input multiplexer through a programmable number of time slots per frame, putting one input in front of the converter in each slot. It runs in a fast system clock domain. A single-cycle enable pulse, `tick`, stands for each period of the 32768 Hz sampling clock. Each tick starts one slot. When a slot starts, the block issues a slot-start pulse, which starts one filter conversion. At the first slot of each frame it also issues a frame-start pulse, which launches one pass of the downstream computation program.

Each slot has two 4-bit select fields: one in a normal bank and one in an alternate bank. Normally the normal bank drives the multiplexer select. Software can raise a request bit to get a single alternate frame, for example to read temperature or the battery voltage. The block catches the rising edge of the request, waits for the next frame boundary, runs exactly one frame from the alternate bank, and then returns to normal frames.

The slot count and both select banks are captured only at a frame boundary, so a frame never mixes old and new settings. A battery-monitor enable output follows a dedicated configuration bit.

Top module: `adc_slot_sequencer`

## Requirements
- R1: After reset, and until the first tick, `slot_idx`, `mux_sel`, `alt_frame`, `slot_start`, `frame_start` and `batt_mon_en` are all 0.
- R2: A `tick` sampled high at a clock edge starts a new slot. After that edge, `slot_start` is high for exactly that one cycle, and `slot_idx` has moved one past the previous slot inside the frame.
- R3: The number of slots per frame equals `slot_cnt_cfg` when it is 1 to 10. A value of 0 gives 1 slot, and any value above 10 gives 10 slots.
- R4: The first tick after reset, and every tick that arrives while the last slot of a frame is active, starts a new frame. In that cycle `slot_idx` is 0 and `frame_start` is high together with `slot_start`. `frame_start` is never high at any other time.
- R5: In a normal frame (`alt_frame` = 0), `mux_sel` equals bits [4n+3:4n] of `norm_sel_cfg`, where n is the current `slot_idx`.
- R6: A rising edge on `alt_req` does not change the frame that is running. The next frame runs with `alt_frame` = 1, and its `mux_sel` comes from bits [4n+3:4n] of `alt_sel_cfg`. The frame after that is normal again, unless a new rising edge arrived in the meantime.
- R7: Only the rising edge of `alt_req` counts. A request that is high for one cycle is still served. A request held high over many frames produces exactly one alternate frame.
- R8: A rising edge of `alt_req` that arrives while an alternate frame is pending or running is merged with it and does not add another alternate frame.
- R9: `slot_cnt_cfg`, `norm_sel_cfg` and `alt_sel_cfg` are captured only when a frame starts. A change during a frame has no effect on `mux_sel` or on the frame length until the next frame.
- R10: `batt_mon_en` equals `batt_en_cfg` delayed by one clock, whatever the frame state.
- R11: Between slot starts, `slot_idx` and `mux_sel` hold their values.
- R12: A rising edge of `alt_req` in the same cycle as the tick that ends a normal frame makes the frame that starts on that tick an alternate frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per 32768 Hz period; each pulse starts a slot |
| slot_cnt_cfg | input | 4 | Requested number of slots per frame (clamped to 1..10) |
| norm_sel_cfg | input | 40 | Normal select bank, 4 bits per slot, slot n at [4n+3:4n] |
| alt_sel_cfg | input | 40 | Alternate select bank, 4 bits per slot, slot n at [4n+3:4n] |
| alt_req | input | 1 | Software alternate-frame request; its rising edge counts |
| batt_en_cfg | input | 1 | Battery-monitor enable bit |
| slot_idx | output | 4 | Index of the current slot |
| mux_sel | output | 4 | Input select applied to the multiplexer |
| alt_frame | output | 1 | High during an alternate frame |
| slot_start | output | 1 | One-cycle pulse at the start of each slot |
| frame_start | output | 1 | One-cycle pulse at the start of each frame |
| batt_mon_en | output | 1 | Battery-monitor enable |

## Verification
Two events can fall in the same cycle: a rising edge of the alternate request and the tick that closes a frame. In that cycle the newly captured edge must decide the type of the frame that begins on that very tick. The bench provokes this by raising `alt_req` in exactly the cycle where its reference model says the last slot is ending. The test is done once after a normal frame and once after an alternate frame. The scoreboard then compares the frame flag and the select values of the following frame: the first case must start an alternate frame, and the second case must be merged.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int SEL_W = 4;
  typedef logic [SEL_W-1:0] sel_t;
endpackage

// File: rtl/seq_req_capture.sv
module seq_req_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  input  logic busy,
  input  logic take,
  output logic pend_eff
);
  logic req_q, pend_q;
  logic req_d, pend_d;
  logic rise;

  always_comb begin
    rise     = req_in & ~req_q;
    pend_eff = pend_q | (rise & ~busy);
    req_d    = req_in;
    pend_d   = take ? 1'b0 : pend_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      pend_q <= pend_d;
    end
  end

  // R8
  merge_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pend_q) |=> !pend_q);
endmodule

// File: rtl/seq_slot_ctrl.sv
module seq_slot_ctrl #(
  parameter int NSLOTS = 10,
  parameter int DIV_W  = 4,
  parameter int SLOT_W = $clog2(NSLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [DIV_W-1:0]  div_cfg,
  input  logic              pend_eff,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              alt_frame,
  output logic              slot_start,
  output logic              frame_start,
  output logic              take
);
  localparam int CW = SLOT_W + 1;

  logic              run_q, run_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [CW-1:0]     cnt_q, cnt_d, cnt_clamp;
  logic              alt_q, alt_d, ss_q, ss_d, fs_q, fs_d;
  logic              boundary;

  always_comb begin
    if (div_cfg == '0)                 cnt_clamp = CW'(1);
    else if (int'(div_cfg) > NSLOTS)   cnt_clamp = CW'(NSLOTS);
    else                               cnt_clamp = CW'(div_cfg);
  end

  always_comb begin
    boundary = !run_q || (({1'b0, slot_q} + 1'b1) == cnt_q);
    take     = tick & boundary;
    run_d  = run_q;
    slot_d = slot_q;
    cnt_d  = cnt_q;
    alt_d  = alt_q;
    ss_d   = 1'b0;
    fs_d   = 1'b0;
    if (tick) begin
      ss_d = 1'b1;
      if (boundary) begin
        run_d  = 1'b1;
        slot_d = '0;
        cnt_d  = cnt_clamp;
        alt_d  = pend_eff;
        fs_d   = 1'b1;
      end else begin
        slot_d = slot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      slot_q <= '0;
      cnt_q  <= '0;
      alt_q  <= 1'b0;
      ss_q   <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      run_q  <= run_d;
      slot_q <= slot_d;
      cnt_q  <= cnt_d;
      alt_q  <= alt_d;
      ss_q   <= ss_d;
      fs_q   <= fs_d;
    end
  end

  assign slot_idx    = slot_q;
  assign alt_frame   = alt_q;
  assign slot_start  = ss_q;
  assign frame_start = fs_q;

  // R3
  slot_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> ({1'b0, slot_q} < cnt_q) && (int'(cnt_q) <= NSLOTS) && (cnt_q != '0));
  // R4
  frame_at_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |-> (ss_q && slot_q == '0));
  // R2
  slot_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_q |-> $past(tick));
  // R6
  alt_only_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_q |-> $stable(alt_q));
endmodule

// File: rtl/seq_bank_latch.sv
module seq_bank_latch
  import seq_pkg::*;
#(
  parameter int NSLOTS = 10,
  parameter int SLOT_W = $clog2(NSLOTS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    use_alt,
  input  logic [NSLOTS*SEL_W-1:0] norm_bank,
  input  logic [NSLOTS*SEL_W-1:0] alt_bank,
  input  logic [SLOT_W-1:0]       slot_idx,
  output sel_t                    sel
);
  logic [NSLOTS*SEL_W-1:0] bank_q, bank_d;
  sel_t fields [NSLOTS];

  always_comb begin
    bank_d = bank_q;
    if (load) bank_d = use_alt ? alt_bank : norm_bank;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_d;
  end

  for (genvar g = 0; g < NSLOTS; g++) begin : g_unpack
    assign fields[g] = bank_q[g*SEL_W +: SEL_W];
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NSLOTS; i++)
      if (slot_idx == SLOT_W'(i)) sel = fields[i];
  end

  // R11
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(slot_idx) && !$past(load)) |-> $stable(sel));
endmodule

// File: rtl/adc_slot_sequencer.sv
module adc_slot_sequencer
  import seq_pkg::*;
#(
  parameter int NSLOTS = 10,
  parameter int DIV_W  = 4,
  localparam int SLOT_W = $clog2(NSLOTS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic [DIV_W-1:0]        slot_cnt_cfg,
  input  logic [NSLOTS*SEL_W-1:0] norm_sel_cfg,
  input  logic [NSLOTS*SEL_W-1:0] alt_sel_cfg,
  input  logic                    alt_req,
  input  logic                    batt_en_cfg,
  output logic [SLOT_W-1:0]       slot_idx,
  output logic [SEL_W-1:0]        mux_sel,
  output logic                    alt_frame,
  output logic                    slot_start,
  output logic                    frame_start,
  output logic                    batt_mon_en
);
  logic pend_eff, take;
  logic batt_q, batt_d;

  seq_req_capture u_req (
    .clk(clk), .rst_n(rst_n), .req_in(alt_req), .busy(alt_frame),
    .take(take), .pend_eff(pend_eff)
  );

  seq_slot_ctrl #(.NSLOTS(NSLOTS), .DIV_W(DIV_W), .SLOT_W(SLOT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .div_cfg(slot_cnt_cfg),
    .pend_eff(pend_eff), .slot_idx(slot_idx), .alt_frame(alt_frame),
    .slot_start(slot_start), .frame_start(frame_start), .take(take)
  );

  seq_bank_latch #(.NSLOTS(NSLOTS), .SLOT_W(SLOT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .load(take), .use_alt(pend_eff),
    .norm_bank(norm_sel_cfg), .alt_bank(alt_sel_cfg),
    .slot_idx(slot_idx), .sel(mux_sel)
  );

  always_comb batt_d = batt_en_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) batt_q <= 1'b0;
    else        batt_q <= batt_d;
  end

  assign batt_mon_en = batt_q;

  // R10
  batt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(batt_mon_en) |-> (batt_mon_en == $past(batt_en_cfg)));
endmodule

// File: tb/sim_adc_slot_sequencer.sv
module sim_adc_slot_sequencer;
  localparam int NS = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic tick, alt_req, batt_en_cfg;
  logic [3:0] slot_cnt_cfg;
  logic [NS*4-1:0] norm_sel_cfg, alt_sel_cfg;
  logic [3:0] slot_idx, mux_sel;
  logic alt_frame, slot_start, frame_start, batt_mon_en;

  always #2 clk = ~clk;

  adc_slot_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .slot_cnt_cfg(slot_cnt_cfg),
    .norm_sel_cfg(norm_sel_cfg), .alt_sel_cfg(alt_sel_cfg), .alt_req(alt_req),
    .batt_en_cfg(batt_en_cfg), .slot_idx(slot_idx), .mux_sel(mux_sel),
    .alt_frame(alt_frame), .slot_start(slot_start), .frame_start(frame_start),
    .batt_mon_en(batt_mon_en)
  );

  typedef struct {
    int    slot;
    int    sel;
    bit    alt;
    bit    fs;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string tag = "R2";

  // reference model
  bit m_run = 0, m_alt = 0, m_pend = 0, m_req_prev = 0;
  int m_slot = 0, m_cnt = 0;
  logic [NS*4-1:0] m_bank = '0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit m_boundary();
    return !m_run || (m_slot + 1 == m_cnt);
  endfunction

  // drive one cycle: inputs set after a negedge, returns at the next negedge
  task automatic cyc(input bit t, input bit r);
    bit rise;
    exp_t e;
    tick    = t;
    alt_req = r;
    rise = r && !m_req_prev;
    m_req_prev = r;
    if (rise && !m_alt) m_pend = 1;
    if (t) begin
      if (m_boundary()) begin
        m_run  = 1;
        m_slot = 0;
        m_cnt  = (slot_cnt_cfg == 0) ? 1 : (slot_cnt_cfg > NS) ? NS : int'(slot_cnt_cfg);
        m_bank = m_pend ? alt_sel_cfg : norm_sel_cfg;
        m_alt  = m_pend;
        m_pend = 0;
        e.fs   = 1;
      end else begin
        m_slot++;
        e.fs = 0;
      end
      e.slot = m_slot;
      e.sel  = int'(m_bank[m_slot*4 +: 4]);
      e.alt  = m_alt;
      e.tag  = tag;
      q.push_back(e);
    end
    @(negedge clk);
  endtask

  // one slot step with idle gaps
  task automatic step(input bit r, input int gap);
    cyc(1'b1, r);
    for (int i = 0; i < gap; i++) cyc(1'b0, r);
  endtask

  // scoreboard monitor
  initial begin
    exp_t last;
    exp_t e;
    last.slot = 0; last.sel = 0; last.alt = 0; last.fs = 0; last.tag = "R1";
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (done) break;
      if (slot_start) begin
        if (q.size() == 0) begin
          chk("R2 unexpected slot_start", 1, 0);
        end else begin
          e = q.pop_front();
          chk({e.tag, " R2 slot_idx"}, int'(slot_idx), e.slot);
          chk({e.tag, " R5 mux_sel"}, int'(mux_sel), e.sel);
          chk({e.tag, " R6 alt_frame"}, int'(alt_frame), int'(e.alt));
          chk({e.tag, " R4 frame_start"}, int'(frame_start), int'(e.fs));
          last = e;
        end
      end else begin
        chk("R4 frame_start idle", int'(frame_start), 0);
        chk("R11 slot_idx hold", int'(slot_idx), last.slot);
        chk("R11 mux_sel hold", int'(mux_sel), last.sel);
      end
    end
  end

  // watchdog
  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 0; alt_req = 0; batt_en_cfg = 0;
    slot_cnt_cfg = 4'd4;
    for (int i = 0; i < NS; i++) begin
      norm_sel_cfg[i*4 +: 4] = 4'(i);
      alt_sel_cfg[i*4 +: 4]  = 4'(15 - i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 slot_idx", int'(slot_idx), 0);
    chk("R1 mux_sel", int'(mux_sel), 0);
    chk("R1 alt_frame", int'(alt_frame), 0);
    chk("R1 slot_start", int'(slot_start), 0);
    chk("R1 frame_start", int'(frame_start), 0);
    chk("R1 batt_mon_en", int'(batt_mon_en), 0);

    // R2 R4 R5: plain normal frames, with gaps and back-to-back ticks
    tag = "R2";
    for (int i = 0; i < 9; i++) step(1'b0, 2);
    for (int i = 0; i < 5; i++) step(1'b0, 0);
    cyc(1'b0, 1'b0);

    // R6 R7: one-cycle request mid-frame
    tag = "R6";
    step(1'b0, 1);
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b0);
    for (int i = 0; i < 12; i++) step(1'b0, 1);

    // R7: request held high across several frames
    tag = "R7";
    for (int i = 0; i < 14; i++) step(1'b1, 1);
    for (int i = 0; i < 6; i++) step(1'b0, 1);

    // R8: second edge while pending, then edge during alternate frame
    tag = "R8";
    step(1'b0, 0);
    cyc(1'b0, 1'b1); cyc(1'b0, 1'b0); cyc(1'b0, 1'b1); cyc(1'b0, 1'b0);
    while (!m_boundary()) step(1'b0, 1);
    step(1'b0, 1);
    cyc(1'b0, 1'b1); cyc(1'b0, 1'b0);
    for (int i = 0; i < 10; i++) step(1'b0, 1);

    // R3: clamp of slot count
    tag = "R3";
    slot_cnt_cfg = 4'd0;
    for (int i = 0; i < 6; i++) step(1'b0, 1);
    slot_cnt_cfg = 4'd15;
    for (int i = 0; i < 24; i++) step(1'b0, 1);
    slot_cnt_cfg = 4'd10;
    for (int i = 0; i < 12; i++) step(1'b0, 1);
    slot_cnt_cfg = 4'd11;
    for (int i = 0; i < 12; i++) step(1'b0, 1);

    // R9: settings changed in the middle of a frame
    tag = "R9";
    slot_cnt_cfg = 4'd6;
    while (!m_boundary()) step(1'b0, 1);
    step(1'b0, 1);
    step(1'b0, 1);
    slot_cnt_cfg = 4'd3;
    for (int i = 0; i < NS; i++) begin
      norm_sel_cfg[i*4 +: 4] = 4'((i * 3 + 5) % 16);
      alt_sel_cfg[i*4 +: 4]  = 4'((i * 7 + 2) % 16);
    end
    cyc(1'b0, 1'b0);
    for (int i = 0; i < 10; i++) step(1'b0, 1);
    cyc(1'b0, 1'b1); cyc(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) step(1'b0, 1);

    // R12: request edge in the same cycle as the frame-ending tick
    tag = "R12";
    slot_cnt_cfg = 4'd5;
    while (!m_boundary()) step(1'b0, 1);
    step(1'b0, 1);
    while (!m_boundary()) step(1'b0, 1);
    chk("R12 model frame normal before edge", int'(m_alt), 0);
    step(1'b1, 0);
    cyc(1'b0, 1'b0);
    chk("R12 alt_frame after coincident edge", int'(alt_frame), 1);
    while (!m_boundary()) step(1'b0, 1);
    step(1'b1, 0);
    cyc(1'b0, 1'b0);
    chk("R8 coincident edge merged", int'(alt_frame), 0);
    for (int i = 0; i < 12; i++) step(1'b0, 1);

    // R10: battery-monitor enable
    batt_en_cfg = 1'b1;
    cyc(1'b0, 1'b0);
    chk("R10 batt_mon_en set", int'(batt_mon_en), 1);
    step(1'b0, 0);
    chk("R10 batt_mon_en during slot", int'(batt_mon_en), 1);
    batt_en_cfg = 1'b0;
    cyc(1'b0, 1'b0);
    chk("R10 batt_mon_en clear", int'(batt_mon_en), 0);

    repeat (3) cyc(1'b0, 1'b0);
    chk("R2 scoreboard drained", q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule